// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache

This block sits between a processor request port and a slower word-wide memory port. It holds a small table of one-word lines. Each line has a valid flag, a tag and a data word. A line is chosen by the low bits of the word address, and the rest of the address is kept as the tag. A read that finds a valid line with a matching tag completes in the same cycle. A read that does not find one raises a stall. The cache then fetches the word over the memory port, installs it, and completes the read once the line holds it.

Stores never wait on memory. Every accepted store updates its line, even when the tag differs, because with one-word lines nothing needs fetching first. The store is also appended to a four-deep posted-write queue, and that queue drains to memory in arrival order whenever the memory port accepts. The processor waits on a store only when the queue is full.

A read miss is never allowed to fetch a stale word. The fetch is held back until the posted-write queue is empty. Only one fetch is outstanding at a time.

Top module: `wt_dm_cache`

## Requirements
- R1: Line index is the word address modulo ENTRIES (low address bits) and the tag is the remaining upper bits; a request hits only when that line is valid and its stored tag equals the request tag.
- R2: After reset every line is invalid, the posted-write queue is empty and `mem_req_valid_o` is low.
- R3: A read hit completes in the cycle it is presented: `stall_o` low, `rvalid_o` high, `rdata_o` equal to the line data.
- R4: A read miss holds `stall_o` high. The cache issues one memory read (`mem_req_write_o`=0) carrying the request address. When `mem_resp_valid_i` arrives, the line takes the returned word, the request tag and a set valid flag. The held read completes in the following cycle with that word.
- R5: On a 4-line cache, the empty-cache read sequence 0,1,2,3,4,3,4,15 stalls on exactly 6 of its 8 accesses (4 evicts 0 from line 0, 15 evicts 3 from line 3).
- R6: An accepted store writes its data and tag into its line and sets the line valid, whether it hit or missed, and performs no memory read; a later read of that address hits with the stored data.
- R7: Accepted stores reach memory as write requests (`mem_req_write_o`=1) in the order they were accepted, each leaving the queue on a cycle where `mem_req_valid_o` and `mem_req_ready_i` are both high; a request not taken stays presented with the same address.
- R8: A store stalls if and only if the posted-write queue holds WB_DEPTH entries.
- R9: A read miss issues its memory read only when the posted-write queue is empty, so a missed read returns the last value stored to that address.
- R10: While a fetch is outstanding no memory request of any kind is presented, and `mem_resp_valid_i` is expected only in that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor request present; held while stalled |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | AW | Word address |
| req_wdata_i | input | DW | Store data |
| stall_o | output | 1 | Request not taken this cycle |
| rvalid_o | output | 1 | Load completes this cycle |
| rdata_o | output | DW | Load data |
| mem_req_valid_o | output | 1 | Memory request presented |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_write_o | output | 1 | 1 = write drain, 0 = line fetch |
| mem_req_addr_o | output | AW | Memory word address |
| mem_req_wdata_o | output | DW | Write data |
| mem_resp_valid_i | input | 1 | Fetch data returned |
| mem_resp_data_i | input | DW | Fetched word |

## Verification
Two functions can collide in one cycle. A store can be pushed into the posted-write queue in the same cycle that the memory port pops the queue head. A stall decision can also be made on a full queue while that queue is draining. The bench provokes both by holding `mem_req_ready_i` low long enough to fill the queue and then releasing it pseudo-randomly while stores keep arriving. A behavioural model built on queues judges every cycle: it checks the stall, the drain order and the drain data. A separate case has a store to one address evicted from its line by a store that shares the index, followed by a read of the first address. The read must wait for the drain and must return the first store's value.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic {FETCH_IDLE = 1'b0, FETCH_WAIT = 1'b1} fetch_state_e;

  function automatic int unsigned idx_bits(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned AW      = 8,
  parameter int unsigned DW      = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] lk_addr_i,
  output logic          lk_hit_o,
  output logic [DW-1:0] lk_data_o,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i
);
  localparam int unsigned IW = wtc_pkg::idx_bits(ENTRIES);
  localparam int unsigned TW = AW - IW;

  logic [ENTRIES-1:0] valid_q;
  logic [TW-1:0]      tag_q  [ENTRIES];
  logic [DW-1:0]      data_q [ENTRIES];

  logic [IW-1:0] lk_idx, wr_idx;
  logic [TW-1:0] lk_tag, wr_tag;

  assign lk_idx = lk_addr_i[IW-1:0];
  assign lk_tag = lk_addr_i[AW-1:IW];
  assign wr_idx = wr_addr_i[IW-1:0];
  assign wr_tag = wr_addr_i[AW-1:IW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else begin
      for (int e = 0; e < int'(ENTRIES); e++) begin
        if (wr_en_i && wr_idx == IW'(e)) valid_q[e] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    for (int e = 0; e < int'(ENTRIES); e++) begin
      if (wr_en_i && wr_idx == IW'(e)) begin
        tag_q[e]  <= wr_tag;
        data_q[e] <= wr_data_i;
      end
    end
  end

  assign lk_hit_o  = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_data_o = data_q[lk_idx];

  // a line just written must hit for the same address next cycle
  assert_write_then_hit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (lk_addr_i != $past(wr_addr_i)) || (wr_en_i && wr_addr_i[IW-1:0] == lk_addr_i[IW-1:0]) || lk_hit_o);
endmodule

// File: rtl/wtc_wbuf.sv
module wtc_wbuf #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [AW-1:0] head_addr_o,
  output logic [DW-1:0] head_data_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int unsigned PW = wtc_pkg::idx_bits(DEPTH);

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [PW:0]   cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o      = (cnt_q == (PW+1)'(DEPTH));
  assign empty_o     = (cnt_q == '0);
  assign head_addr_o = addr_q[rd_ptr_q];
  assign head_data_o = data_q[rd_ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      addr_q[wr_ptr_q] <= push_addr_i;
      data_q[wr_ptr_q] <= push_data_i;
    end
  end

  assert_no_push_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_no_pop_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/wtc_mem_port.sv
module wtc_mem_port #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wb_empty_i,
  input  logic [AW-1:0] wb_addr_i,
  input  logic [DW-1:0] wb_data_i,
  output logic          wb_pop_o,
  input  logic          miss_i,
  input  logic [AW-1:0] miss_addr_i,
  output logic          fill_en_o,
  output logic [AW-1:0] fill_addr_o,
  output logic [DW-1:0] fill_data_o,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic          mem_req_write_o,
  output logic [AW-1:0] mem_req_addr_o,
  output logic [DW-1:0] mem_req_wdata_o,
  input  logic          mem_resp_valid_i,
  input  logic [DW-1:0] mem_resp_data_i
);
  import wtc_pkg::*;

  fetch_state_e  state_q;
  logic [AW-1:0] fetch_addr_q;
  logic          idle;

  assign idle = (state_q == FETCH_IDLE);

  // queued writes go first: a fetch waits until the queue is empty
  assign mem_req_valid_o = idle && (!wb_empty_i || miss_i);
  assign mem_req_write_o = !wb_empty_i;
  assign mem_req_addr_o  = !wb_empty_i ? wb_addr_i : miss_addr_i;
  assign mem_req_wdata_o = wb_data_i;
  assign wb_pop_o        = mem_req_valid_o && mem_req_write_o && mem_req_ready_i;

  assign fill_en_o   = !idle && mem_resp_valid_i;
  assign fill_addr_o = fetch_addr_q;
  assign fill_data_o = mem_resp_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= FETCH_IDLE;
      fetch_addr_q <= '0;
    end else begin
      case (state_q)
        FETCH_IDLE: if (mem_req_valid_o && !mem_req_write_o && mem_req_ready_i) begin
          state_q      <= FETCH_WAIT;
          fetch_addr_q <= miss_addr_i;
        end
        FETCH_WAIT: if (mem_resp_valid_i) state_q <= FETCH_IDLE;
        default:    state_q <= FETCH_IDLE;
      endcase
    end
  end

  assert_req_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));
  assert_resp_in_window_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_resp_valid_i |-> !idle);
  assert_fetch_after_drain_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && mem_req_ready_i && !mem_req_write_o) |=> wb_empty_i);
endmodule

// File: rtl/wt_dm_cache.sv
module wt_dm_cache #(
  parameter int unsigned ENTRIES  = 4,
  parameter int unsigned WB_DEPTH = 4,
  parameter int unsigned AW       = 8,
  parameter int unsigned DW       = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          stall_o,
  output logic          rvalid_o,
  output logic [DW-1:0] rdata_o,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic          mem_req_write_o,
  output logic [AW-1:0] mem_req_addr_o,
  output logic [DW-1:0] mem_req_wdata_o,
  input  logic          mem_resp_valid_i,
  input  logic [DW-1:0] mem_resp_data_i
);
  logic          hit;
  logic [DW-1:0] line_data;
  logic          wb_full, wb_empty, wb_pop;
  logic [AW-1:0] wb_addr;
  logic [DW-1:0] wb_data;
  logic          fill_en;
  logic [AW-1:0] fill_addr;
  logic [DW-1:0] fill_data;
  logic          rd_miss, acc_write;
  logic          ts_we;
  logic [AW-1:0] ts_waddr;
  logic [DW-1:0] ts_wdata;

  assign rd_miss   = req_valid_i && !req_write_i && !hit;
  assign acc_write = req_valid_i && req_write_i && !wb_full;
  assign stall_o   = rd_miss || (req_valid_i && req_write_i && wb_full);
  assign rvalid_o  = req_valid_i && !req_write_i && hit;
  assign rdata_o   = line_data;

  assign ts_we    = acc_write || fill_en;
  assign ts_waddr = fill_en ? fill_addr : req_addr_i;
  assign ts_wdata = fill_en ? fill_data : req_wdata_i;

  wtc_tag_store #(.ENTRIES(ENTRIES), .AW(AW), .DW(DW)) u_tags (
    .clk_i, .rst_ni,
    .lk_addr_i(req_addr_i), .lk_hit_o(hit), .lk_data_o(line_data),
    .wr_en_i(ts_we), .wr_addr_i(ts_waddr), .wr_data_i(ts_wdata)
  );

  wtc_wbuf #(.DEPTH(WB_DEPTH), .AW(AW), .DW(DW)) u_wbuf (
    .clk_i, .rst_ni,
    .push_i(acc_write), .push_addr_i(req_addr_i), .push_data_i(req_wdata_i),
    .pop_i(wb_pop), .head_addr_o(wb_addr), .head_data_o(wb_data),
    .full_o(wb_full), .empty_o(wb_empty)
  );

  wtc_mem_port #(.AW(AW), .DW(DW)) u_mport (
    .clk_i, .rst_ni,
    .wb_empty_i(wb_empty), .wb_addr_i(wb_addr), .wb_data_i(wb_data), .wb_pop_o(wb_pop),
    .miss_i(rd_miss), .miss_addr_i(req_addr_i),
    .fill_en_o(fill_en), .fill_addr_o(fill_addr), .fill_data_o(fill_data),
    .mem_req_valid_o, .mem_req_ready_i, .mem_req_write_o,
    .mem_req_addr_o, .mem_req_wdata_o,
    .mem_resp_valid_i, .mem_resp_data_i
  );

  assert_fill_store_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fill_en && acc_write));
  assert_fill_then_hit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_en && req_valid_i && !req_write_i && req_addr_i == fill_addr) |=>
      (!req_valid_i || req_write_i || req_addr_i != $past(req_addr_i) || !stall_o));
endmodule

// File: tb/sim_wt_dm_cache.sv
`timescale 1ns/1ps
module sim_wt_dm_cache;
  localparam int ENT = 4;
  localparam int WBD = 4;
  localparam int AW  = 8;
  localparam int DW  = 32;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic stall_o, rvalid_o;
  logic [DW-1:0] rdata_o;
  logic mem_req_valid_o, mem_req_write_o;
  logic mem_req_ready_i = 1'b0;
  logic [AW-1:0] mem_req_addr_o;
  logic [DW-1:0] mem_req_wdata_o;
  logic mem_resp_valid_i = 1'b0;
  logic [DW-1:0] mem_resp_data_i = '0;

  always #2 clk = ~clk;

  wt_dm_cache #(.ENTRIES(ENT), .WB_DEPTH(WBD), .AW(AW), .DW(DW)) u0 (
    .clk_i(clk), .rst_ni, .req_valid_i, .req_write_i, .req_addr_i, .req_wdata_i,
    .stall_o, .rvalid_o, .rdata_o,
    .mem_req_valid_o, .mem_req_ready_i, .mem_req_write_o, .mem_req_addr_o,
    .mem_req_wdata_o, .mem_resp_valid_i, .mem_resp_data_i
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  bit            mv   [ENT];
  int            mtag [ENT];
  logic [DW-1:0] mdat [ENT];
  logic [AW-1:0] qa[$];
  logic [DW-1:0] qd[$];
  logic [DW-1:0] mem [1<<AW];
  bit            pend = 0;
  int            lat_cnt = 0;
  logic [AW-1:0] pend_addr = '0;
  logic [15:0]   lfsr = 16'hACE1;

  // processor op list and results
  bit            op_w[$];
  logic [AW-1:0] op_a[$];
  logic [DW-1:0] op_d[$];
  bit            acc_miss[$];
  logic [DW-1:0] acc_rdata[$];
  int            cur = 0;
  bit            cur_stalled = 0;

  task automatic chk(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", what, act, exp, $time);
    end
  endtask

  task automatic add_op(input bit w, input int a, input logic [DW-1:0] d);
    op_w.push_back(w); op_a.push_back(AW'(a)); op_d.push_back(d);
  endtask

  task automatic step(input bit hold_nready);
    bit rv, w, hit, es, emv, ew;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    int idx, tg, fi;
    rv = (cur < op_w.size());
    w  = rv ? op_w[cur] : 1'b0;
    a  = rv ? op_a[cur] : '0;
    d  = rv ? op_d[cur] : '0;
    req_valid_i = rv; req_write_i = w; req_addr_i = a; req_wdata_i = d;
    mem_req_ready_i  = !hold_nready && (lfsr[1:0] != 2'b00);
    mem_resp_valid_i = pend && (lat_cnt == 0);
    mem_resp_data_i  = mem_resp_valid_i ? mem[pend_addr] : '0;
    #1;
    idx = int'(a) % ENT; tg = int'(a) / ENT;
    hit = mv[idx] && (mtag[idx] == tg);
    es  = rv && (w ? (qa.size() == WBD) : !hit);
    chk(w ? "R8 store stall" : "R4 load stall", DW'(stall_o), DW'(es));
    chk("R3 rvalid", DW'(rvalid_o), DW'(rv && !w && !es));
    if (rv && !w && !es) chk("R3 rdata", rdata_o, mdat[idx]);
    emv = !pend && (qa.size() > 0 || (rv && !w && !hit));
    chk("R9/R10 mem request valid", DW'(mem_req_valid_o), DW'(emv));
    if (emv && mem_req_valid_o) begin
      ew = (qa.size() > 0);
      chk("R7 mem write flag", DW'(mem_req_write_o), DW'(ew));
      if (ew) begin
        chk("R7 drain addr", DW'(mem_req_addr_o), DW'(qa[0]));
        chk("R7 drain data", mem_req_wdata_o, qd[0]);
      end else begin
        chk("R4 fetch addr", DW'(mem_req_addr_o), DW'(a));
      end
    end
    if (rv && stall_o) cur_stalled = 1;
    // model update for the coming edge
    if (mem_resp_valid_i) begin
      fi = int'(pend_addr) % ENT;
      mv[fi] = 1; mtag[fi] = int'(pend_addr) / ENT; mdat[fi] = mem[pend_addr];
      pend = 0;
    end else if (pend) begin
      lat_cnt--;
    end
    if (emv && mem_req_ready_i) begin
      if (qa.size() > 0) begin
        mem[qa[0]] = qd[0];
        void'(qa.pop_front()); void'(qd.pop_front());
      end else begin
        pend = 1; lat_cnt = LAT - 1; pend_addr = a;
      end
    end
    if (rv && !es) begin
      if (w) begin
        mv[idx] = 1; mtag[idx] = tg; mdat[idx] = d;
        qa.push_back(a); qd.push_back(d);
        acc_rdata.push_back('0);
      end else begin
        acc_rdata.push_back(rdata_o);
      end
      acc_miss.push_back(cur_stalled);
      cur_stalled = 0;
      cur++;
    end
    @(posedge clk);
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic run(input int nready_cycles);
    int n = 0;
    while (cur < op_w.size() || qa.size() > 0 || pend) begin
      step(n < nready_cycles);
      n++;
    end
    repeat (2) step(1'b0);
  endtask

  function automatic logic [DW-1:0] init_word(input int i);
    return {8'hA5, 8'(i), 16'(i * 37)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int b, missn;
    for (int i = 0; i < (1 << AW); i++) mem[i] = init_word(i);
    for (int i = 0; i < ENT; i++) begin mv[i] = 0; mtag[i] = 0; mdat[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R2 stall in reset", DW'(stall_o), 0);
    chk("R2 mem request in reset", DW'(mem_req_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R2 mem request after reset", DW'(mem_req_valid_o), 0);

    // reference string on an empty cache
    b = cur;
    foreach (op_w[i]) ;
    add_op(0, 0, '0); add_op(0, 1, '0); add_op(0, 2, '0); add_op(0, 3, '0);
    add_op(0, 4, '0); add_op(0, 3, '0); add_op(0, 4, '0); add_op(0, 15, '0);
    run(0);
    missn = 0;
    for (int i = 0; i < 8; i++) begin
      chk($sformatf("R1 hit/miss of access %0d", i), DW'(acc_miss[b+i]),
          DW'((i == 5 || i == 6) ? 0 : 1));
      missn += acc_miss[b+i];
    end
    chk("R5 miss count", DW'(missn), 6);
    chk("R2 first access after reset misses", DW'(acc_miss[b]), 1);
    chk("R4 fetched word for 15", acc_rdata[b+7], init_word(15));

    // stores against a blocked memory port fill the queue
    b = cur;
    for (int k = 0; k < 8; k++) add_op(1, 20 + k, 32'hC0DE_0000 + k);
    run(30);
    missn = 0;
    for (int k = 0; k < 8; k++) missn += acc_miss[b+k];
    chk("R8 queue-full stall seen", DW'(missn > 0), 1);
    chk("R8 first four stores free", DW'(acc_miss[b] | acc_miss[b+1] | acc_miss[b+2] | acc_miss[b+3]), 0);
    for (int k = 0; k < 8; k++)
      chk($sformatf("R7 memory word %0d", 20 + k), mem[20+k], 32'hC0DE_0000 + k);

    // same-index eviction while the store is still queued
    b = cur;
    add_op(1, 5, 32'h1111_5555);
    add_op(1, 9, 32'h2222_9999);
    add_op(0, 9, '0);
    add_op(0, 5, '0);
    run(10);
    chk("R6 store-miss installs, read hits", DW'(acc_miss[b+2]), 0);
    chk("R6 installed data", acc_rdata[b+2], 32'h2222_9999);
    chk("R9 evicted read misses", DW'(acc_miss[b+3]), 1);
    chk("R9 no stale fetch", acc_rdata[b+3], 32'h1111_5555);

    // mixed traffic
    for (int k = 0; k < 400; k++) begin
      bit w;
      w = ($urandom_range(0, 9) < 4);
      add_op(w, int'($urandom_range(0, 31)), $urandom());
    end
    run(0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule